// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a keypad of up to thirty keys wired as six scan lines crossed with five sense inputs. While no key is down it drives a fixed pattern on the scan lines and does nothing else. When any sense input reads high, it walks a single high level across the scan lines and records the five sense inputs for each line. It does this twice, back to back, and accepts the key image only if both passes agree and a key is still down at the end of the acceptance window. Once it accepts an image, it latches the image and pulls an active-low read request toward the serial interface block.

The serial block owns chip-enable and a read-complete strobe. A high chip-enable masks the request while a transfer runs. The read-complete strobe clears the request and starts a fresh scan pair, which either reports again or drops back to idle once all keys are up. A two-bit sleep code chooses which scan lines idle high. Only keys on those lines can wake the scanner, and the code also gates an oscillator-enable output. An active-low blank input clears the latched image and holds the scanner idle. All timing advances on a base tick input, which the clock qualifies.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset in sleep code 2'b00, scan_o is all ones, req_n_o is 1, key_o is 0 and osc_en_o is 1. A scan pair starts on the first tick on which any sense_i bit is 1.
- R2: While scanning, scan line k (k = 1..6, scan_o bit k-1) is the only line high, for SCAN_TICKS/6 ticks each, in ascending order. A line that the sleep code holds low is never driven high. Between the end of the second pass and the decision, scan_o returns to its idle pattern.
- R3: The key at scan line k and sense input j (sense_i bit j-1) is key number 5(k-1)+j. It appears on key_o bit 5(k-1)+j-1.
- R4: The decision falls on the REQ_TICKS-th tick after the tick that started the pair (default 25600, scan pass 12000). req_n_o goes to 0 after that tick only if both passes matched, the image is nonzero and a sense input is still high. A press released earlier gives no request. key_o holds steady while the request is pending.
- R5: If the two passes differ and a key is still down at the decision, a new pair starts at once. The request then comes 2*REQ_TICKS ticks after the first start and carries the image of the later pair.
- R6: While ce_i is 1, req_n_o is 1. When ce_i returns to 0 and the request is still pending, req_n_o returns to 0.
- R7: A read_done_i pulse during a pending request releases req_n_o and starts a new pair. A held key gives a fresh request REQ_TICKS ticks later. With all keys released, the block returns to idle with no request.
- R8: The idle scan_o pattern follows sleep_i: 2'b00 gives all ones, 2'b10 gives only line 6 high, 2'b01 gives lines 2 to 6 high, and 2'b11 gives all ones. osc_en_o is 1 in code 2'b00 or whenever the scanner is not idle. It is 0 when idle under any nonzero code.
- R9: In sleep, a key on a line held low has no effect: osc_en_o stays 0 and no request follows. A key on a high line starts a scan, raises osc_en_o and gets reported.
- R10: While blank_ni is 0, key_o is 0, no scan runs, scan_o shows the idle pattern and req_n_o is 1 even with ce_i at 0. Scanning resumes once blank_ni returns to 1.
- R11: Scan timing advances only on cycles with tick_i at 1. With tick_i at 0, a pressed key does not start a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base timing tick, one clock wide |
| blank_ni | input | 1 | Active-low blank: clears key image, halts scanning |
| sleep_i | input | 2 | Sleep code selecting idle scan-line levels |
| sense_i | input | SENSE | Sense inputs from the key matrix |
| ce_i | input | 1 | Chip-enable from the serial block |
| read_done_i | input | 1 | Pulse marking completion of a key readout |
| scan_o | output | LINES | Scan line drive |
| req_n_o | output | 1 | Active-low read request |
| key_o | output | LINES*SENSE | Accepted key image |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The hardest case to reach is a pair whose two passes disagree while a key stays down. This case forces the restart path and the doubled latency. The bench models the matrix as a combinational function of scan_o and a pressed-key vector, so the stimulus can switch the pressed key on the exact tick that separates the two passes. It then confirms that the request arrives one full pair later and carries the second image. The acceptance boundary gets the same treatment: one press is released one tick before the decision and one is held through it.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } kscan_state_e;
endpackage

// File: rtl/key_scan_timer.sv
module key_scan_timer #(
  parameter int LINES      = 6,
  parameter int SCAN_TICKS = 12000,
  parameter int REQ_TICKS  = 25600
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         run_i,
  output logic [$clog2(LINES+1)-1:0]   line_o,
  output logic                         pass_o,
  output logic                         active_o,
  output logic                         slot_end_o,
  output logic                         pair_end_o
);
  localparam int SLOT = SCAN_TICKS / LINES;
  localparam int SW   = $clog2(SLOT + 1);
  localparam int LW   = $clog2(LINES + 1);
  localparam int CW   = $clog2(REQ_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slot_q;
  logic [LW-1:0] line_q;
  logic          pass_q, act_q;
  logic          slot_last;

  assign slot_last  = (slot_q == SW'(SLOT - 1));
  assign slot_end_o = run_i && act_q && slot_last;
  assign pair_end_o = run_i && (cnt_q == CW'(REQ_TICKS - 1));
  assign line_o     = line_q;
  assign pass_o     = pass_q;
  assign active_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
      line_q <= '0;
      pass_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
      line_q <= '0;
      pass_q <= 1'b0;
      act_q  <= 1'b1;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (act_q) begin
        if (slot_last) begin
          slot_q <= '0;
          if (line_q == LW'(LINES - 1)) begin
            line_q <= '0;
            if (pass_q) act_q <= 1'b0;
            else        pass_q <= 1'b1;
          end else begin
            line_q <= line_q + 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/key_scan_capture.sv
module key_scan_capture #(
  parameter int LINES = 6,
  parameter int SENSE = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic                        pass_i,
  input  logic [$clog2(LINES+1)-1:0]  line_i,
  input  logic [SENSE-1:0]            sense_i,
  output logic                        match_o,
  output logic                        any_o,
  output logic [LINES*SENSE-1:0]      img_o
);
  logic [SENSE-1:0] first_q  [LINES];
  logic [SENSE-1:0] second_q [LINES];
  logic [LINES-1:0] row_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        first_q[i]  <= '0;
        second_q[i] <= '0;
      end
    end else if (wr_i) begin
      if (pass_i) second_q[line_i] <= sense_i;
      else        first_q[line_i]  <= sense_i;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_row
    assign row_eq[g]                   = (first_q[g] == second_q[g]);
    assign img_o[g*SENSE +: SENSE]     = second_q[g];
  end

  assign match_o = &row_eq;
  assign any_o   = |img_o;
endmodule

// File: rtl/key_scan_ctrl.sv
module key_scan_ctrl
  import key_scan_pkg::*;
#(
  parameter int KEYS = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            blank_ni,
  input  logic            tick_i,
  input  logic            sense_any_i,
  input  logic            pair_end_i,
  input  logic            match_i,
  input  logic            img_any_i,
  input  logic [KEYS-1:0] img_i,
  input  logic            read_done_i,
  output kscan_state_e    state_o,
  output logic            restart_o,
  output logic [KEYS-1:0] key_o
);
  kscan_state_e state_q, state_d;
  logic [KEYS-1:0] key_q;
  logic load;

  always_comb begin
    state_d   = state_q;
    restart_o = 1'b0;
    load      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (tick_i && sense_any_i) begin
        state_d   = ST_SCAN;
        restart_o = 1'b1;
      end
      ST_SCAN: if (pair_end_i) begin
        if (sense_any_i && match_i && img_any_i) begin
          state_d = ST_HOLD;
          load    = 1'b1;
        end else if (sense_any_i) begin
          restart_o = 1'b1;   // disagreement or empty image with key still down
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: if (read_done_i) begin
        state_d   = ST_SCAN;
        restart_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!blank_ni) begin
      state_d   = ST_IDLE;
      restart_o = 1'b0;
      load      = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      key_q   <= '0;
    end else begin
      state_q <= state_d;
      if (!blank_ni) key_q <= '0;
      else if (load) key_q <= img_i;
    end
  end

  assign state_o = state_q;
  assign key_o   = key_q;
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
  import key_scan_pkg::*;
#(
  parameter int LINES      = 6,
  parameter int SENSE      = 5,
  parameter int SCAN_TICKS = 12000,
  parameter int REQ_TICKS  = 25600
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     blank_ni,
  input  logic [1:0]               sleep_i,
  input  logic [SENSE-1:0]         sense_i,
  input  logic                     ce_i,
  input  logic                     read_done_i,
  output logic [LINES-1:0]         scan_o,
  output logic                     req_n_o,
  output logic [LINES*SENSE-1:0]   key_o,
  output logic                     osc_en_o
);
  localparam int KEYS = LINES * SENSE;
  localparam int LW   = $clog2(LINES + 1);

  kscan_state_e     state;
  logic             restart, run, active, pass, slot_end, pair_end;
  logic             match, img_any, scanning, st_idle;
  logic [LW-1:0]    line;
  logic [KEYS-1:0]  img;
  logic [LINES-1:0] mask, walk;

  // idle scan-line levels per sleep code; top line always high
  for (genvar g = 0; g < LINES; g++) begin : g_mask
    if (g == LINES - 1) begin : g_top
      assign mask[g] = 1'b1;
    end else if (g == 0) begin : g_first
      assign mask[g] = (sleep_i == 2'b00) || (sleep_i == 2'b11);
    end else begin : g_mid
      assign mask[g] = (sleep_i != 2'b10);
    end
  end

  assign run      = (state == ST_SCAN) && tick_i;
  assign scanning = (state == ST_SCAN) && active;
  assign st_idle  = (state == ST_IDLE);
  assign walk     = LINES'(1) << line;
  assign scan_o   = scanning ? (walk & mask) : mask;
  assign req_n_o  = !((state == ST_HOLD) && !ce_i);
  assign osc_en_o = (sleep_i == 2'b00) || !st_idle;

  key_scan_timer #(
    .LINES(LINES), .SCAN_TICKS(SCAN_TICKS), .REQ_TICKS(REQ_TICKS)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart), .run_i(run),
    .line_o(line), .pass_o(pass), .active_o(active),
    .slot_end_o(slot_end), .pair_end_o(pair_end)
  );

  key_scan_capture #(.LINES(LINES), .SENSE(SENSE)) capture_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(slot_end), .pass_i(pass),
    .line_i(line), .sense_i(sense_i),
    .match_o(match), .any_o(img_any), .img_o(img)
  );

  key_scan_ctrl #(.KEYS(KEYS)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .blank_ni(blank_ni), .tick_i(tick_i),
    .sense_any_i(|sense_i), .pair_end_i(pair_end), .match_i(match),
    .img_any_i(img_any), .img_i(img), .read_done_i(read_done_i),
    .state_o(state), .restart_o(restart), .key_o(key_o)
  );
endmodule

// File: rtl/key_scan_checker.sv
module key_scan_checker #(
  parameter int LINES = 6,
  parameter int KEYS  = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_ni,
  input logic             ce_i,
  input logic [1:0]       sleep_i,
  input logic [LINES-1:0] scan_o,
  input logic             req_n_o,
  input logic [KEYS-1:0]  key_o,
  input logic             osc_en_o,
  input logic             scanning,
  input logic             st_idle
);
  AST_SCAN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning |-> $onehot0(scan_o)); // R2
  AST_IDLE_TOP_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_idle |-> scan_o[LINES-1]); // R8
  AST_OSC_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i == 2'b00) |-> osc_en_o); // R8
  AST_OSC_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> st_idle); // R9
  AST_CE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |-> req_n_o); // R6
  AST_BLANK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> req_n_o); // R10
  AST_BLANK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> (key_o == '0)); // R10
  AST_KEY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_n_o && $past(!req_n_o)) |-> $stable(key_o)); // R4
endmodule

bind key_matrix_scanner key_scan_checker #(.LINES(LINES), .KEYS(KEYS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .blank_ni(blank_ni), .ce_i(ce_i),
  .sleep_i(sleep_i), .scan_o(scan_o), .req_n_o(req_n_o), .key_o(key_o),
  .osc_en_o(osc_en_o), .scanning(scanning), .st_idle(st_idle)
);

// File: tb/key_matrix_scanner_tb_top.sv
module key_matrix_scanner_tb_top;
  localparam int LINES = 6;
  localparam int SENSE = 5;
  localparam int KEYS  = LINES * SENSE;
  localparam int SCAN  = 120;
  localparam int REQ   = 256;
  localparam int SLOT  = SCAN / LINES;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, tick_i = 1'b1, blank_ni = 1'b1, ce_i = 1'b0, read_done_i = 1'b0;
  logic [1:0] sleep_i = 2'b00;
  logic [SENSE-1:0] sense_i;
  logic [LINES-1:0] scan_o;
  logic req_n_o, osc_en_o;
  logic [KEYS-1:0] key_o;
  logic [KEYS-1:0] pressed = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // key matrix: sense j high if a pressed key sits on a driven line
  always_comb begin
    for (int j = 0; j < SENSE; j++) begin
      sense_i[j] = 1'b0;
      for (int k = 0; k < LINES; k++)
        sense_i[j] = sense_i[j] | (scan_o[k] & pressed[k*SENSE+j]);
    end
  end

  key_matrix_scanner #(.LINES(LINES), .SENSE(SENSE), .SCAN_TICKS(SCAN), .REQ_TICKS(REQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .blank_ni(blank_ni), .sleep_i(sleep_i),
    .sense_i(sense_i), .ce_i(ce_i), .read_done_i(read_done_i), .scan_o(scan_o),
    .req_n_o(req_n_o), .key_o(key_o), .osc_en_o(osc_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_and_read();
    pressed = '0;
    read_done_i = 1'b1;
    negs(1);
    read_done_i = 1'b0;
    negs(REQ + 2);
    chk("R7 idle after release", {scan_o, req_n_o}, {6'b111111, 1'b1});
  endtask

  task automatic t_reset();
    chk("R1 reset scan", scan_o, 6'b111111);
    chk("R1 reset req", req_n_o, 1);
    chk("R1 reset key", key_o, 0);
    chk("R1 reset osc", osc_en_o, 1);
  endtask

  task automatic t_accept();
    pressed = (30'd1 << 2) | (30'd1 << 19);   // line1/sense3, line4/sense5
    negs(1);
    chk("R1 R2 first line", scan_o, 6'b000001);
    negs(SLOT);
    chk("R2 second line", scan_o, 6'b000010);
    negs(REQ - 1 - SLOT);
    chk("R2 idle pattern in window", scan_o, 6'b111111);
    chk("R4 no request before decision", req_n_o, 1);
    negs(1);
    chk("R4 request at decision", req_n_o, 0);
    chk("R3 key image", key_o, (30'd1 << 2) | (30'd1 << 19));
    release_and_read();
  endtask

  task automatic t_short();
    pressed = 30'd1 << 7;
    negs(REQ);
    pressed = '0;
    negs(1);
    chk("R4 short press no request", req_n_o, 1);
    negs(20);
    chk("R4 short press stays quiet", {req_n_o, scan_o}, {1'b1, 6'b111111});
    // boundary: held through decision
    pressed = 30'd1 << 7;
    negs(REQ + 1);
    chk("R4 minimum press reported", req_n_o, 0);
    chk("R3 line2 sense3", key_o, 30'd1 << 7);
    release_and_read();
  endtask

  task automatic t_mismatch();
    pressed = 30'd1 << 2;
    negs(SCAN + 1);
    pressed = 30'd1 << 12;
    negs(2*REQ - SCAN - 1);
    chk("R5 no request at first decision", req_n_o, 1);
    negs(1);
    chk("R5 request after second pair", req_n_o, 0);
    chk("R5 later image", key_o, 30'd1 << 12);
  endtask

  task automatic t_ce_read();
    ce_i = 1'b1; #1;
    chk("R6 ce masks request", req_n_o, 1);
    negs(1);
    ce_i = 1'b0; #1;
    chk("R6 request returns", req_n_o, 0);
    negs(1);
    read_done_i = 1'b1;
    negs(1);
    read_done_i = 1'b0;
    chk("R7 read clears request", req_n_o, 1);
    negs(REQ - 1);
    chk("R7 no early re-request", req_n_o, 1);
    negs(1);
    chk("R7 held key re-requested", req_n_o, 0);
    release_and_read();
  endtask

  task automatic t_sleep_levels();
    sleep_i = 2'b10; #1;
    chk("R8 code10", {scan_o, osc_en_o}, {6'b100000, 1'b0});
    sleep_i = 2'b01; #1;
    chk("R8 code01", {scan_o, osc_en_o}, {6'b111110, 1'b0});
    sleep_i = 2'b11; #1;
    chk("R8 code11", {scan_o, osc_en_o}, {6'b111111, 1'b0});
    sleep_i = 2'b00; #1;
    chk("R8 code00", {scan_o, osc_en_o}, {6'b111111, 1'b1});
    negs(1);
  endtask

  task automatic t_wake();
    sleep_i = 2'b10;
    pressed = 30'd1 << 2;
    negs(40);
    chk("R9 low-line key ignored", {osc_en_o, req_n_o}, {1'b0, 1'b1});
    pressed = (30'd1 << 2) | (30'd1 << 26);
    negs(1);
    chk("R9 wake osc", osc_en_o, 1);
    chk("R2 masked line not driven", scan_o, 6'b000000);
    negs(REQ - 1);
    chk("R9 no early request", req_n_o, 1);
    negs(1);
    chk("R9 wake request", req_n_o, 0);
    chk("R3 R9 line6 sense2 only", key_o, 30'd1 << 26);
    pressed = '0;
    read_done_i = 1'b1;
    negs(1);
    read_done_i = 1'b0;
    negs(REQ + 2);
    chk("R9 back to sleep idle", {osc_en_o, req_n_o, scan_o}, {1'b0, 1'b1, 6'b100000});
    sleep_i = 2'b00;
    negs(1);
  endtask

  task automatic t_blank();
    pressed = 30'd1;
    negs(REQ + 1);
    chk("R10 setup request", req_n_o, 0);
    blank_ni = 1'b0;
    negs(1);
    chk("R10 blank releases req", req_n_o, 1);
    chk("R10 blank clears key", key_o, 0);
    negs(REQ + 10);
    chk("R10 no scan during blank", {req_n_o, scan_o, key_o}, {1'b1, 6'b111111, 30'd0});
    blank_ni = 1'b1;
    negs(1);
    chk("R10 scan resumes", scan_o, 6'b000001);
    negs(REQ);
    chk("R10 request after blank", req_n_o, 0);
    release_and_read();
  endtask

  task automatic t_tick();
    tick_i = 1'b0;
    pressed = 30'd1;
    negs(30);
    chk("R11 no start without tick", {scan_o, req_n_o}, {6'b111111, 1'b1});
    tick_i = 1'b1;
    negs(1);
    chk("R11 start on tick", scan_o, 6'b000001);
    pressed = '0;
    negs(REQ + 2);
    chk("R11 returns idle", {scan_o, req_n_o}, {6'b111111, 1'b1});
  endtask

  initial begin
    negs(3);
    rst_ni = 1'b1;
    negs(1);
    t_reset();
    t_accept();
    t_short();
    t_mismatch();
    t_ce_read();
    t_sleep_levels();
    t_wake();
    t_blank();
    t_tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule